// File: doc/BRIEF.md
# Gated Physical Timer Register Frame

This block is a memory-mapped physical timer. It keeps a 64-bit compare value and compares it with a free-running 64-bit system count supplied from outside. A 32-bit control register holds an enable bit, an interrupt-mask bit and a read-only status bit. A signed 32-bit down-counting timer value is derived from the compare value and the count. Software can also reach the compare value directly, one 32-bit half at a time. A level interrupt is raised while the timer is enabled, the compare condition holds and the interrupt is not masked.

The same registers appear in two address windows on a simple register bus (address, write enable, write data, combinational read data). The top address bit selects the window: 0 is the privileged view and 1 is the user view. Each view has its own gate, driven by permission inputs. When a view is blocked, every register in that view reads as zero and ignores writes. Offsets that are not implemented behave the same way. Clearing the enable bit only silences the output. The timer value keeps moving with the count.

Top module: `ptmr_frame`

## Requirements
- R1: After reset, enable, mask and the compare value are 0: CTL reads 0x0, both compare halves read 0x0, and irq_o is 0.
- R2: CTL sits at offset 0x02C. Bit 0 is the enable bit and bit 1 is the mask bit, and both are read/write. Bits 31:3 always read 0 and ignore writes.
- R3: CTL bit 2 (status) is read-only. Writing it has no effect. With the timer enabled it reads 1 exactly when (count − compare), taken as a signed 64-bit value, is ≥ 0, and the mask bit does not affect it.
- R4: While the enable bit is 0, status reads 0.
- R5: irq_o is 1 exactly when enable = 1, status condition = 1 and mask = 0.
- R6: TVAL at offset 0x028 reads (compare − count)[31:0]. Writing it sets compare to count plus the sign-extended written value.
- R7: The compare value is readable and writable as a low half at offset 0x020 and a high half at offset 0x024.
- R8: In the privileged view (address bit 12 = 0), the registers are accessible only when priv_perm_i = 1. Otherwise reads return 0 and writes are ignored.
- R9: In the user view (address bit 12 = 1), the registers are accessible only when priv_perm_i = 1 and user_en_i = 1. Otherwise reads return 0 and writes are ignored.
- R10: Any other offset reads as 0, and writes to it change no state.
- R11: With enable = 0, TVAL still decreases by one for each increment of the count, and irq_o stays 0.
- R12: The compare is signed and wraps. A compare value 2^63 above the count is not met, and a compare of all ones (−1) against a small positive count is met.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W (13) | Byte address; the top bit selects the user view |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Combinational read data for addr_i |
| count_i | input | 2*DATA_W (64) | Free-running system count |
| priv_perm_i | input | 1 | Permission for the privileged view |
| user_en_i | input | 1 | Extra user-view enable |
| irq_o | output | 1 | Level timer interrupt |

## Verification
The compare is tried with the count just below, at, and past the compare point. Compare values are loaded both through TVAL with positive and negative deltas and through the two halves. Together these separate a strict test from a ≥ test and show that sign extension works. Wrapped cases, with the compare 2^63 ahead and with a compare of −1, separate a signed difference from an unsigned magnitude compare. Every permission combination is applied in both views, and each is read back through the open privileged view to show that a blocked write left the state unchanged. A sweep of the count with the timer disabled shows that the timer value keeps counting while the output stays low.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int unsigned OFF_CVAL_LO = 'h020;
  localparam int unsigned OFF_CVAL_HI = 'h024;
  localparam int unsigned OFF_TVAL    = 'h028;
  localparam int unsigned OFF_CTL     = 'h02C;

  localparam int unsigned CTL_EN   = 0;
  localparam int unsigned CTL_MASK = 1;
  localparam int unsigned CTL_STAT = 2;

  typedef struct packed {
    logic ctl;
    logic tval;
    logic cval_hi;
    logic cval_lo;
  } reg_sel_t;
endpackage

// File: rtl/ptmr_access.sv
module ptmr_access (
  input  logic user_view_i,
  input  logic priv_perm_i,
  input  logic user_en_i,
  output logic ok_o
);
  localparam int unsigned N_VIEWS = 2;
  logic [N_VIEWS-1:0] view_ok;

  // view 0: privileged, view 1: user (needs privileged access too)
  generate
    for (genvar v = 0; v < N_VIEWS; v++) begin : g_view
      if (v == 0) begin : g_priv
        assign view_ok[v] = priv_perm_i;
      end else begin : g_user
        assign view_ok[v] = view_ok[v-1] & user_en_i;
      end
    end
  endgenerate

  assign ok_o = view_ok[user_view_i];
endmodule

// File: rtl/ptmr_decode.sv
module ptmr_decode
  import ptmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ok_i,
  output logic              user_view_o,
  output reg_sel_t          sel_o
);
  localparam int unsigned OFF_W = ADDR_W - 1;

  logic [OFF_W-1:0] off;
  assign off         = addr_i[OFF_W-1:0];
  assign user_view_o = addr_i[ADDR_W-1];

  always_comb begin
    sel_o         = '0;
    sel_o.ctl     = ok_i && (off == OFF_W'(OFF_CTL));
    sel_o.tval    = ok_i && (off == OFF_W'(OFF_TVAL));
    sel_o.cval_hi = ok_i && (off == OFF_W'(OFF_CVAL_HI));
    sel_o.cval_lo = ok_i && (off == OFF_W'(OFF_CVAL_LO));
  end
endmodule

// File: rtl/ptmr_core.sv
module ptmr_core
  import ptmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2*DATA_W-1:0] count_i,
  input  reg_sel_t            sel_i,
  input  logic                wr_en_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                irq_o
);
  localparam int unsigned CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0] cval_q;
  logic             en_q, mask_q;
  logic [CNT_W-1:0] diff;      // count - compare
  logic             cond_met;
  logic             stat;
  logic [CNT_W-1:0] wdata_sx;

  assign diff     = count_i - cval_q;
  assign cond_met = ~diff[CNT_W-1];
  assign stat     = en_q & cond_met;
  assign irq_o    = stat & ~mask_q;
  assign wdata_sx = {{DATA_W{wdata_i[DATA_W-1]}}, wdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cval_q <= '0;
      en_q   <= 1'b0;
      mask_q <= 1'b0;
    end else if (wr_en_i) begin
      if (sel_i.ctl) begin
        en_q   <= wdata_i[CTL_EN];
        mask_q <= wdata_i[CTL_MASK];
      end
      if (sel_i.tval)    cval_q <= count_i + wdata_sx;
      if (sel_i.cval_lo) cval_q[DATA_W-1:0] <= wdata_i;
      if (sel_i.cval_hi) cval_q[CNT_W-1:DATA_W] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i.ctl) begin
      rdata_o[CTL_EN]   = en_q;
      rdata_o[CTL_MASK] = mask_q;
      rdata_o[CTL_STAT] = stat;
    end
    if (sel_i.tval)    rdata_o = DATA_W'(-diff);
    if (sel_i.cval_lo) rdata_o = cval_q[DATA_W-1:0];
    if (sel_i.cval_hi) rdata_o = cval_q[CNT_W-1:DATA_W];
  end

  p_tval_wr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i.tval) |=> cval_q == $past(count_i) + {{DATA_W{$past(wdata_i[DATA_W-1])}}, $past(wdata_i)});

  p_no_sel_wi_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i == '0) |=> ($stable(cval_q) && $stable(en_q) && $stable(mask_q)));

  p_ctl_upper_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i.ctl |-> rdata_o[DATA_W-1:3] == '0);

  p_stat_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i.ctl && !en_q) |-> !rdata_o[CTL_STAT]);

  p_irq_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i.ctl && !wdata_i[CTL_EN]) |=> !irq_o);
endmodule

// File: rtl/ptmr_frame.sv
module ptmr_frame
  import ptmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 13
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [2*DATA_W-1:0] count_i,
  input  logic                priv_perm_i,
  input  logic                user_en_i,
  output logic                irq_o
);
  logic     user_view;
  logic     access_ok;
  reg_sel_t sel;

  ptmr_access u_access (
    .user_view_i (user_view),
    .priv_perm_i (priv_perm_i),
    .user_en_i   (user_en_i),
    .ok_o        (access_ok)
  );

  ptmr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i      (addr_i),
    .ok_i        (access_ok),
    .user_view_o (user_view),
    .sel_o       (sel)
  );

  ptmr_core #(.DATA_W(DATA_W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .count_i (count_i),
    .sel_i   (sel),
    .wr_en_i (wr_en_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o)
  );

  p_raz_priv_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!addr_i[ADDR_W-1] && !priv_perm_i) |-> rdata_o == '0);

  p_raz_user_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[ADDR_W-1] && !(priv_perm_i && user_en_i)) |-> rdata_o == '0);

  p_sel_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel));
endmodule

// File: tb/tb_ptmr_frame.sv
module tb_ptmr_frame;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 13;
  localparam logic [AW-1:0] UV      = 13'h1000;
  localparam logic [AW-1:0] A_CLO   = 13'h020;
  localparam logic [AW-1:0] A_CHI   = 13'h024;
  localparam logic [AW-1:0] A_TVAL  = 13'h028;
  localparam logic [AW-1:0] A_CTL   = 13'h02C;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [63:0]   cnt = '0;
  logic          pperm = 1'b1;
  logic          uen = 1'b0;
  logic          irq;
  int            total = 0;
  int            bad = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  ptmr_frame #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .count_i(cnt), .priv_perm_i(pperm), .user_en_i(uen), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0; addr = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic set_cnt(input logic [63:0] c);
    @(negedge clk); cnt = c;
  endtask

  task automatic t_reset;
    logic [DW-1:0] d;
    rd(A_CTL, d); chk("R1 ctl", d, 0);
    rd(A_CLO, d); chk("R1 cval lo", d, 0);
    rd(A_CHI, d); chk("R1 cval hi", d, 0);
    chk("R1 irq", DW'(irq), 0);
  endtask

  task automatic t_ctl_fields;
    logic [DW-1:0] d;
    set_cnt(64'd0);
    wr(A_CTL, 32'hFFFF_FFFF);
    rd(A_CTL, d); chk("R2 ctl all ones", d, 32'h7);
    chk("R5 masked irq", DW'(irq), 0);
    wr(A_CTL, 32'h1);
    rd(A_CTL, d); chk("R3 status ignores mask", d, 32'h5);
    chk("R5 irq", DW'(irq), 1);
    wr(A_CTL, 32'h4);
    rd(A_CTL, d); chk("R3 R4 status not writable", d, 32'h0);
    chk("R5 irq off", DW'(irq), 0);
  endtask

  task automatic t_compare;
    logic [DW-1:0] d;
    wr(A_CTL, 32'h1);
    set_cnt(64'd1000);
    wr(A_TVAL, 32'd100);
    rd(A_TVAL, d); chk("R6 tval read", d, 32'd100);
    rd(A_CLO, d); chk("R7 cval lo", d, 32'd1100);
    set_cnt(64'd1099);
    rd(A_CTL, d); chk("R3 below", d, 32'h1);
    chk("R5 below", DW'(irq), 0);
    set_cnt(64'd1100);
    rd(A_CTL, d); chk("R3 equal", d, 32'h5);
    chk("R5 equal", DW'(irq), 1);
    wr(A_TVAL, 32'hFFFF_FFFB);
    rd(A_CLO, d); chk("R6 negative tval", d, 32'd1095);
    rd(A_TVAL, d); chk("R6 tval -5", d, 32'hFFFF_FFFB);
  endtask

  task automatic t_signed;
    logic [DW-1:0] d;
    set_cnt(64'd5);
    wr(A_CHI, 32'h8000_0000);
    wr(A_CLO, 32'h5);
    rd(A_CHI, d); chk("R7 cval hi", d, 32'h8000_0000);
    rd(A_CTL, d); chk("R12 far ahead not met", d, 32'h1);
    chk("R12 irq", DW'(irq), 0);
    wr(A_CHI, 32'hFFFF_FFFF);
    wr(A_CLO, 32'hFFFF_FFFF);
    rd(A_CTL, d); chk("R12 minus one met", d, 32'h5);
    chk("R12 irq", DW'(irq), 1);
  endtask

  task automatic t_disabled_counts;
    logic [DW-1:0] d;
    set_cnt(64'd2000);
    wr(A_TVAL, 32'd50);
    wr(A_CTL, 32'h0);
    set_cnt(64'd2010);
    rd(A_TVAL, d); chk("R11 tval counts", d, 32'd40);
    set_cnt(64'd2060);
    rd(A_TVAL, d); chk("R11 tval negative", d, 32'hFFFF_FFF6);
    rd(A_CTL, d); chk("R4 status off", d, 32'h0);
    chk("R11 irq low", DW'(irq), 0);
  endtask

  task automatic t_priv_gate;
    logic [DW-1:0] d;
    wr(A_CTL, 32'h2);
    wr(A_CLO, 32'h1234);
    @(negedge clk); pperm = 1'b0;
    rd(A_CTL, d); chk("R8 raz ctl", d, 0);
    rd(A_CLO, d); chk("R8 raz cval", d, 0);
    wr(A_CTL, 32'h1);
    wr(A_CLO, 32'hDEAD);
    @(negedge clk); pperm = 1'b1;
    rd(A_CTL, d); chk("R8 ctl write ignored", d, 32'h2);
    rd(A_CLO, d); chk("R8 cval write ignored", d, 32'h1234);
  endtask

  task automatic t_user_gate;
    logic [DW-1:0] d;
    @(negedge clk); pperm = 1'b1; uen = 1'b0;
    rd(UV | A_CTL, d); chk("R9 raz no user en", d, 0);
    wr(UV | A_CTL, 32'h1);
    rd(A_CTL, d); chk("R9 write ignored no user en", d, 32'h2);
    @(negedge clk); pperm = 1'b0; uen = 1'b1;
    rd(UV | A_CLO, d); chk("R9 raz no priv", d, 0);
    wr(UV | A_CTL, 32'h1);
    @(negedge clk); pperm = 1'b1;
    rd(A_CTL, d); chk("R9 write ignored no priv", d, 32'h2);
    wr(UV | A_CTL, 32'h3);
    rd(UV | A_CTL, d); chk("R9 user write", d, 32'h3);
    rd(A_CTL, d); chk("R9 shared state", d, 32'h3);
    @(negedge clk); uen = 1'b0;
  endtask

  task automatic t_unimpl;
    logic [DW-1:0] d;
    wr(13'h030, 32'hFFFF_FFFF);
    wr(13'h000, 32'hFFFF_FFFF);
    wr(13'h02D, 32'h0);
    rd(13'h030, d); chk("R10 raz", d, 0);
    rd(13'h02D, d); chk("R10 raz unaligned", d, 0);
    rd(A_CTL, d); chk("R10 ctl unchanged", d[1:0], 32'h3);
    rd(A_CLO, d); chk("R10 cval unchanged", d, 32'h1234);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctl_fields();
    t_compare();
    t_signed();
    t_disabled_counts();
    t_priv_gate();
    t_user_gate();
    t_unimpl();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule